// File: doc/BRIEF.md
# Per-Bank Row Keep-Open Predictor

This block sits beside a DRAM command scheduler and advises it, bank by bank, whether a row should be left open after it has been accessed or precharged early. Each bank owns two small saturating history counters, one for reads and one for writes. A column command issued to a bank rewards that bank's counter of the matching direction. An activate issued to a bank penalises both of its counters. A bank whose accesses keep hitting the open row therefore builds up credit. A bank that keeps reopening rows loses it.

The scheduler tells the block whether it is currently serving reads or draining writes. For every bank, the block compares the counter of that direction against a threshold parameter and presents a registered keep-open flag per bank. When a flag is low, that bank is a candidate for early precharge. The block issues no commands of its own, enforces no timing and holds no requests.

Top module: `dram_row_keep_predictor`

## Requirements
- R1: While `rst` is high at a clock edge, every counter is loaded with `THRESH`. At that same edge, every bit of `keep_open` becomes 1.
- R2: A column command with `col_is_write`=0 at bank `col_bank` raises that bank's read counter by one, unless an activate reaches the same bank in the same cycle.
- R3: An activate at bank `act_bank` lowers both the read and the write counter of that bank by one.
- R4: A column command with `col_is_write`=1 raises that bank's write counter by one, unless an activate reaches the same bank in the same cycle.
- R5: A counter at its maximum value (2^CNT_W−1, which is 15 for 4 bits) stays there when raised. It never wraps to zero.
- R6: A counter at 0 stays at 0 when lowered. It never wraps to the maximum.
- R7: When a column command and an activate reach the same bank in one cycle, the counter of the column command's direction holds its value. The other counter of that bank is still lowered by the activate.
- R8: `keep_open[b]` is set at each clock edge from the values before that edge. It is 1 when the selected counter of bank b is at least `THRESH`, and 0 otherwise. The selected counter is the write counter when `write_mode`=1 and the read counter when `write_mode`=0.
- R9: Commands addressed to one bank leave the counters of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| write_mode | input | 1 | 1 selects write counters for the decision, 0 selects read counters |
| col_valid | input | 1 | A column command was issued this cycle |
| col_is_write | input | 1 | 1 means the column command is a write, 0 means a read |
| col_bank | input | BANK_W | Bank of the column command |
| act_valid | input | 1 | An activate was issued this cycle |
| act_bank | input | BANK_W | Bank of the activate |
| keep_open | output | NUM_BANKS | Registered per-bank flag: 1 keeps the row open, 0 advises early precharge |

## Verification
The bench builds the block with 4 banks, 4-bit counters and a threshold of 6. With these values, the ceiling of 15 is reached after nine reads or writes and the floor after six activates, so both saturation limits are crossed and then pushed against within a few dozen cycles. Because the threshold is not centred in the counter range, a wrap at either end changes the flag after a different number of steps than a correct saturation does. A reference model of the counters predicts all four flags every cycle. Phases cover same-cycle collisions on one bank, mode flips on a bank whose read and write histories disagree, and a pseudo-random command mix across all banks.

// File: rtl/dram_keep_pkg.sv
`timescale 1ns/1ps
package dram_keep_pkg;

  // Direction of a column command
  typedef enum logic {
    COL_READ  = 1'b0,
    COL_WRITE = 1'b1
  } col_dir_e;

  // Per-bank update strobes produced by the decoder
  typedef struct packed {
    logic rd_inc;
    logic wr_inc;
    logic act_dec;
  } bank_upd_t;

endpackage

// File: rtl/bank_cmd_decode.sv
`timescale 1ns/1ps
module bank_cmd_decode
  import dram_keep_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                  col_valid,
  input  logic                  col_is_write,
  input  logic [BANK_W-1:0]     col_bank,
  input  logic                  act_valid,
  input  logic [BANK_W-1:0]     act_bank,
  output bank_upd_t             upd [NUM_BANKS]
);

  col_dir_e dir;
  assign dir = col_dir_e'(col_is_write);

  // One comparator pair per bank
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic col_here;
    logic act_here;
    assign col_here = col_valid && (col_bank == BANK_W'(b));
    assign act_here = act_valid && (act_bank == BANK_W'(b));
    always_comb begin
      upd[b].rd_inc  = col_here && (dir == COL_READ);
      upd[b].wr_inc  = col_here && (dir == COL_WRITE);
      upd[b].act_dec = act_here;
    end
  end

endmodule

// File: rtl/sat_hist_ctr.sv
`timescale 1ns/1ps
module sat_hist_ctr #(
  parameter int CNT_W = 4,
  parameter int INIT  = 8,
  localparam logic [CNT_W-1:0] CMAX  = {CNT_W{1'b1}},
  localparam logic [CNT_W-1:0] CINIT = CNT_W'(INIT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt
);

  logic up_ok;
  logic dn_ok;
  assign up_ok = inc && !dec && (cnt != CMAX);
  assign dn_ok = dec && !inc && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst)        cnt <= CINIT;
    else if (up_ok) cnt <= cnt + 1'b1;
    else if (dn_ok) cnt <= cnt - 1'b1;
  end

  // R2/R4: single increment step
  a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && cnt != CMAX) |=> (cnt == $past(cnt) + 1'b1));

  // R3: single decrement step
  a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R5: no wrap at the top
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (cnt == CMAX && inc) |=> (cnt == CMAX));

  // R6: no wrap at the bottom
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && dec) |=> (cnt == '0));

  // R7: simultaneous reward and penalty cancel
  a_r7_cancel: assert property (@(posedge clk) disable iff (rst)
    (inc && dec) |=> $stable(cnt));

endmodule

// File: rtl/bank_open_slice.sv
`timescale 1ns/1ps
module bank_open_slice
  import dram_keep_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int THRESH = 8,
  localparam logic [CNT_W-1:0] TH = CNT_W'(THRESH)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      write_mode,
  input  bank_upd_t upd,
  output logic      keep_open
);

  logic [CNT_W-1:0] rd_cnt;
  logic [CNT_W-1:0] wr_cnt;
  logic [CNT_W-1:0] sel_cnt;

  sat_hist_ctr #(.CNT_W(CNT_W), .INIT(THRESH)) u_rd_hist (
    .clk (clk),
    .rst (rst),
    .inc (upd.rd_inc),
    .dec (upd.act_dec),
    .cnt (rd_cnt)
  );

  sat_hist_ctr #(.CNT_W(CNT_W), .INIT(THRESH)) u_wr_hist (
    .clk (clk),
    .rst (rst),
    .inc (upd.wr_inc),
    .dec (upd.act_dec),
    .cnt (wr_cnt)
  );

  assign sel_cnt = write_mode ? wr_cnt : rd_cnt;

  always_ff @(posedge clk) begin
    if (rst) keep_open <= 1'b1;
    else     keep_open <= (sel_cnt >= TH);
  end

  // R8: read mode with a weak read history closes the row next cycle
  a_r8_read_close: assert property (@(posedge clk) disable iff (rst)
    (!write_mode && rd_cnt < TH) |=> !keep_open);

  // R8: write mode with a strong write history keeps the row next cycle
  a_r8_write_keep: assert property (@(posedge clk) disable iff (rst)
    (write_mode && wr_cnt >= TH) |=> keep_open);

endmodule

// File: rtl/dram_row_keep_predictor.sv
`timescale 1ns/1ps
module dram_row_keep_predictor
  import dram_keep_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 4,
  parameter int THRESH    = 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  write_mode,
  input  logic                  col_valid,
  input  logic                  col_is_write,
  input  logic [BANK_W-1:0]     col_bank,
  input  logic                  act_valid,
  input  logic [BANK_W-1:0]     act_bank,
  output logic [NUM_BANKS-1:0]  keep_open
);

  bank_upd_t upd [NUM_BANKS];

  bank_cmd_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .col_valid    (col_valid),
    .col_is_write (col_is_write),
    .col_bank     (col_bank),
    .act_valid    (act_valid),
    .act_bank     (act_bank),
    .upd          (upd)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slice
    bank_open_slice #(.CNT_W(CNT_W), .THRESH(THRESH)) u_slice (
      .clk        (clk),
      .rst        (rst),
      .write_mode (write_mode),
      .upd        (upd[b]),
      .keep_open  (keep_open[b])
    );

    // R9: an idle bank with an unchanged mode keeps its flag
    a_r9_isolated: assert property (@(posedge clk) disable iff (rst)
      (!upd[b].rd_inc && !upd[b].wr_inc && !upd[b].act_dec &&
       !$past(rst) && $stable(write_mode) &&
       !$past(upd[b].rd_inc) && !$past(upd[b].wr_inc) && !$past(upd[b].act_dec))
      |=> $stable(keep_open[b]));
  end

  // R1: reset leaves every bank in the keep-open state
  a_r1_reset_open: assert property (@(posedge clk)
    rst |=> (&keep_open));

endmodule

// File: tb/sim_dram_row_keep_predictor.sv
`timescale 1ns/1ps
module sim_dram_row_keep_predictor;

  localparam int NB  = 4;
  localparam int CW  = 4;
  localparam int TH  = 6;
  localparam int MX  = (1 << CW) - 1;
  localparam int BW  = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          write_mode = 1'b0;
  logic          col_valid = 1'b0;
  logic          col_is_write = 1'b0;
  logic [BW-1:0] col_bank = '0;
  logic          act_valid = 1'b0;
  logic [BW-1:0] act_bank = '0;
  logic [NB-1:0] keep_open;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int rd_m [NB];
  int wr_m [NB];

  always #2 clk = ~clk;

  dram_row_keep_predictor #(.NUM_BANKS(NB), .CNT_W(CW), .THRESH(TH)) u0 (
    .clk          (clk),
    .rst          (rst),
    .write_mode   (write_mode),
    .col_valid    (col_valid),
    .col_is_write (col_is_write),
    .col_bank     (col_bank),
    .act_valid    (act_valid),
    .act_bank     (act_bank),
    .keep_open    (keep_open)
  );

  task automatic compare(input logic [NB-1:0] exp, input string tag);
    for (int b = 0; b < NB; b++) begin
      checks++;
      if (keep_open[b] !== exp[b]) begin
        errors++;
        $display("FAIL %s bank %0d keep_open actual %0b expected %0b",
                 tag, b, keep_open[b], exp[b]);
      end
    end
  endtask

  // One clock of stimulus; model updated from the requirements
  task automatic step(input logic m, input logic cv, input logic cw, input int cb,
                      input logic av, input int ab, input string tag);
    logic [NB-1:0] exp;
    @(negedge clk);
    write_mode   = m;
    col_valid    = cv;
    col_is_write = cw;
    col_bank     = BW'(cb);
    act_valid    = av;
    act_bank     = BW'(ab);
    for (int b = 0; b < NB; b++)
      exp[b] = ((m ? wr_m[b] : rd_m[b]) >= TH);   // R8
    @(posedge clk);
    for (int b = 0; b < NB; b++) begin
      bit ri = cv && !cw && (cb == b);
      bit wi = cv &&  cw && (cb == b);
      bit ad = av && (ab == b);
      if (ri && !ad)      rd_m[b] = (rd_m[b] < MX) ? rd_m[b] + 1 : MX;   // R2 R5
      else if (ad && !ri) rd_m[b] = (rd_m[b] > 0) ? rd_m[b] - 1 : 0;    // R3 R6
      if (wi && !ad)      wr_m[b] = (wr_m[b] < MX) ? wr_m[b] + 1 : MX;   // R4 R5
      else if (ad && !wi) wr_m[b] = (wr_m[b] > 0) ? wr_m[b] - 1 : 0;    // R7 when both
    end
    #1;
    compare(exp, tag);
  endtask

  initial begin : watchdog
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    for (int b = 0; b < NB; b++) begin rd_m[b] = TH; wr_m[b] = TH; end
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    compare('1, "R1 reset");
    @(negedge clk);
    rst = 1'b0;
    step(0, 0, 0, 0, 0, 0, "R1 idle after reset");

    // R2 and R5: reads drive bank 0 to the ceiling and push against it
    for (int i = 0; i < 12; i++) step(0, 1, 0, 0, 0, 0, "R2/R5 read ceiling");
    // R3 and R6: activates walk bank 0 down through threshold to the floor
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1, 0, "R3/R6 act floor");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0, 0, "R6 climb from floor");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, "R6 settle");

    // R4: writes to bank 1 in write mode
    for (int i = 0; i < 11; i++) step(1, 1, 1, 1, 0, 0, "R4/R5 write ceiling");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 1, 1, "R3 write act");

    // R7: collisions on banks 2 and 3
    for (int i = 0; i < 4; i++) step(0, 1, 0, 2, 1, 2, "R7 read+act");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 3, 1, 3, "R7 write+act");
    step(1, 0, 0, 0, 0, 0, "R7 write counter bank2 lowered");
    step(0, 0, 0, 0, 0, 0, "R7 read counter bank3 lowered");

    // R8: flip mode with banks whose read and write histories differ
    for (int i = 0; i < 6; i++) begin
      step(i[0], 0, 0, 0, 0, 0, "R8 mode select");
    end

    // R9: mixed traffic across banks
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[9], lfsr[0], lfsr[1], int'(lfsr[3:2]),
           lfsr[4] & lfsr[7], int'(lfsr[6:5]), "R9 mixed");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule